// File: doc/BRIEF.md
# Supply-Detect Reset Release Sequencer

This block keeps a display-driver system in reset after the supply-voltage detector fires. Reset stays active until every display-data group needed by the chosen duty mode, together with the control data, has arrived over the serial interface. Release happens on the chip-enable falling edge that closes the last missing group. The serial shift register, waveform generation, key scanning and the analog detector sit outside this block.

Each frame reaches the block as a chip-enable strobe. The frame carries a group code and a frame-valid flag. The frame interface has no ready signal and no back-pressure. The block takes every chip-enable falling edge in the cycle it is seen, so the sender never waits. A frame whose group the current duty mode does not use is dropped, and so is a frame without the valid flag. The outputs are a reset level and the forced states it implies for the display, key scan and shared pins.

Top module: `por_release_seq`

## Requirements
- R1: When `vdet_i` rises, `sys_rst_o` goes high at once, without waiting for a clock edge, and stays high while `vdet_i` is high.
- R2: While `sys_rst_o` is high, `disp_en_o` and `scan_en_o` are 0 and `key_zero_o` is 1. When it is low, these three outputs take the opposite values.
- R3: While `sys_rst_o` is high, every bit of `pin_hold_o` is 1. This forces shared pins 0 to 3 to segment function driven low and pin 4 to port function driven low. When `sys_rst_o` is low, `pin_hold_o` is all zeros.
- R4: A chip-enable falling edge is a clock edge where `ce_i` is 0 and was 1 at the edge before. At that same edge, the frame's group code is taken from `grp_i` and its valid flag from `frame_ok_i`.
- R5: With `duty3_i`=0 (quarter duty), release needs group codes 0, 1, 2 and 3.
- R6: With `duty3_i`=1 (third duty), release needs group codes 0, 1 and 2. A frame with code 3 is ignored.
- R7: Groups may arrive in any order, and a repeated group has no further effect.
- R8: `sys_rst_o` falls right after the clock edge that sees the falling edge completing the set. It never falls before that edge.
- R9: A frame with `frame_ok_i`=0 is ignored.
- R10: Once released, the block stays released until the next `vdet_i` pulse, whatever frames follow.
- R11: A new `vdet_i` pulse clears every received group, so the full set is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; `ce_i`, `grp_i`, `frame_ok_i` synchronous to it |
| vdet_i | input | 1 | Supply-detect pulse, active high, asynchronous |
| ce_i | input | 1 | Chip-enable strobe of the serial interface |
| duty3_i | input | 1 | 1 = third-duty mode, 0 = quarter-duty mode |
| grp_i | input | GRP_W (2) | Group code of the current frame |
| frame_ok_i | input | 1 | Frame carries valid data |
| sys_rst_o | output | 1 | System reset level |
| disp_en_o | output | 1 | Display enable |
| scan_en_o | output | 1 | Key-scan enable |
| key_zero_o | output | 1 | Forces all key data to zero |
| pin_hold_o | output | N_PINS (5) | Per shared pin: forced to reset function and low |

## Verification
Frames are sent in ascending order, in scrambled order and with repeats. This shows whether release depends on the full set or only on a count or a sequence. Frames with the valid flag cleared, and code-3 frames in third-duty mode, are placed just before the completing frame, so accepting either one would release reset one frame too early. Frames sent after release, and a detector pulse arriving after a partial set, show whether the release latch holds and whether old group marks are cleared.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef struct packed {
    logic fall;
    logic ok;
  } ce_evt_t;

  function automatic logic grp_used(input int idx, input logic duty3,
                                    input int n_full, input int n_third);
    return duty3 ? (idx < n_third) : (idx < n_full);
  endfunction

endpackage

// File: rtl/ce_fall_det.sv
module ce_fall_det (
  input  logic                   clk_i,
  input  logic                   vdet_i,
  input  logic                   ce_i,
  input  logic                   frame_ok_i,
  output por_seq_pkg::ce_evt_t   evt_o
);
  logic ce_q;

  always_ff @(posedge clk_i or posedge vdet_i) begin
    if (vdet_i) ce_q <= 1'b0;
    else        ce_q <= ce_i;
  end

  assign evt_o.fall = ce_q & ~ce_i;
  assign evt_o.ok   = frame_ok_i;

endmodule

// File: rtl/grp_tracker.sv
module grp_tracker #(
  parameter int N_GROUPS   = 4,
  parameter int N_GROUPS_3 = 3,
  localparam int GRP_W = $clog2(N_GROUPS)
) (
  input  logic                  clk_i,
  input  logic                  vdet_i,
  input  por_seq_pkg::ce_evt_t  evt_i,
  input  logic                  duty3_i,
  input  logic [GRP_W-1:0]      grp_i,
  output logic [N_GROUPS-1:0]   need_o,
  output logic [N_GROUPS-1:0]   got_o
);
  logic [N_GROUPS-1:0] got_q;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic hit;
    assign need_o[g] = por_seq_pkg::grp_used(g, duty3_i, N_GROUPS, N_GROUPS_3);
    assign hit = evt_i.fall & evt_i.ok & need_o[g] & (grp_i == GRP_W'(g));

    always_ff @(posedge clk_i or posedge vdet_i) begin
      if (vdet_i)   got_q[g] <= 1'b0;
      else if (hit) got_q[g] <= 1'b1;
    end

    AST_MARK_ON_FALL: assert property (@(posedge clk_i) disable iff (vdet_i)
      $rose(got_q[g]) |-> $past(evt_i.fall && evt_i.ok)); // R4
  end

  assign got_o = got_q;

  if (N_GROUPS > N_GROUPS_3) begin : g_unused_chk
    AST_UNUSED_IGNORED: assert property (@(posedge clk_i) disable iff (vdet_i)
      $rose(got_q[N_GROUPS-1]) |-> $past(!duty3_i)); // R6
  end

endmodule

// File: rtl/release_ctrl.sv
module release_ctrl #(
  parameter int N_GROUPS = 4
) (
  input  logic                clk_i,
  input  logic                vdet_i,
  input  logic                fall_i,
  input  logic [N_GROUPS-1:0] need_i,
  input  logic [N_GROUPS-1:0] got_i,
  output logic                sys_rst_o
);
  logic released_q;
  logic all_in;

  assign all_in = &(got_i | ~need_i);

  always_ff @(posedge clk_i or posedge vdet_i) begin
    if (vdet_i)      released_q <= 1'b0;
    else if (all_in) released_q <= 1'b1;
  end

  assign sys_rst_o = vdet_i | ~(released_q | all_in);

  AST_STAY_RELEASED: assert property (@(posedge clk_i) disable iff (vdet_i)
    !sys_rst_o |=> !sys_rst_o); // R10

  AST_RELEASE_ON_FALL: assert property (@(posedge clk_i) disable iff (vdet_i)
    $fell(sys_rst_o) |-> $past(fall_i)); // R8

  AST_HELD_AFTER_DET: assert property (@(posedge clk_i) disable iff (vdet_i)
    $fell(vdet_i) |-> sys_rst_o); // R11

endmodule

// File: rtl/por_release_seq.sv
module por_release_seq #(
  parameter int N_GROUPS   = 4,
  parameter int N_GROUPS_3 = 3,
  parameter int N_PINS     = 5,
  localparam int GRP_W = $clog2(N_GROUPS)
) (
  input  logic              clk_i,
  input  logic              vdet_i,
  input  logic              ce_i,
  input  logic              duty3_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              frame_ok_i,
  output logic              sys_rst_o,
  output logic              disp_en_o,
  output logic              scan_en_o,
  output logic              key_zero_o,
  output logic [N_PINS-1:0] pin_hold_o
);
  por_seq_pkg::ce_evt_t evt;
  logic [N_GROUPS-1:0]  need;
  logic [N_GROUPS-1:0]  got;
  logic                 rst_int;

  ce_fall_det u_fall (
    .clk_i(clk_i), .vdet_i(vdet_i), .ce_i(ce_i),
    .frame_ok_i(frame_ok_i), .evt_o(evt)
  );

  grp_tracker #(.N_GROUPS(N_GROUPS), .N_GROUPS_3(N_GROUPS_3)) u_track (
    .clk_i(clk_i), .vdet_i(vdet_i), .evt_i(evt), .duty3_i(duty3_i),
    .grp_i(grp_i), .need_o(need), .got_o(got)
  );

  release_ctrl #(.N_GROUPS(N_GROUPS)) u_rel (
    .clk_i(clk_i), .vdet_i(vdet_i), .fall_i(evt.fall),
    .need_i(need), .got_i(got), .sys_rst_o(rst_int)
  );

  assign sys_rst_o  = rst_int;
  assign disp_en_o  = ~rst_int;
  assign scan_en_o  = ~rst_int;
  assign key_zero_o = rst_int;
  assign pin_hold_o = {N_PINS{rst_int}};

  always_comb begin
    if (vdet_i) AST_ASYNC_RST: assert (sys_rst_o); // R1
  end

endmodule

// File: tb/test_por_release_seq.sv
module test_por_release_seq;
  logic       clk = 1'b0;
  logic       vdet, ce, duty3, ok;
  logic [1:0] grp;
  logic       sys_rst, disp_en, scan_en, key_zero;
  logic [4:0] pin_hold;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit    rst;
    string req;
  } exp_t;
  exp_t q[$];
  event chk_ev;

  bit [3:0] m_got;
  bit       m_rel;

  always #2.5 clk = ~clk;

  por_release_seq i_por_release_seq (
    .clk_i(clk), .vdet_i(vdet), .ce_i(ce), .duty3_i(duty3), .grp_i(grp),
    .frame_ok_i(ok), .sys_rst_o(sys_rst), .disp_en_o(disp_en),
    .scan_en_o(scan_en), .key_zero_o(key_zero), .pin_hold_o(pin_hold)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        logic [8:0] act, expv;
        e = q.pop_front();
        act  = {sys_rst, disp_en, scan_en, key_zero, pin_hold};
        expv = {e.rst, !e.rst, !e.rst, e.rst, {5{e.rst}}};
        checks++;
        if (act !== expv) begin
          errors++;
          $display("FAIL %s: outputs %b expected %b", e.req, act, expv);
        end
      end
    end
  end

  task automatic expect_now(input string req);
    exp_t e;
    e.rst = !m_rel;
    e.req = req;
    q.push_back(e);
    -> chk_ev;
    #0.1;
  endtask

  task automatic pulse_vdet(input string req);
    @(negedge clk);
    #1 vdet = 1'b1;
    m_got = '0; m_rel = 1'b0;
    #0.5 expect_now(req);          // R1: async, before any clock edge
    @(negedge clk); @(negedge clk);
    vdet = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input int g, input bit v, input string req);
    @(negedge clk);
    ce = 1'b1; grp = 2'(g); ok = v;
    @(negedge clk);
    ce = 1'b0;                      // fall seen at next posedge
    if (!expect_pending_release(g, v)) ;
    @(negedge clk);
    expect_now(req);
    ok = 1'b0;
  endtask

  function automatic bit expect_pending_release(input int g, input bit v);
    bit [3:0] need;
    need = duty3 ? 4'b0111 : 4'b1111;
    if (v && need[g]) m_got[g] = 1'b1;
    if ((m_got & need) == need) m_rel = 1'b1;
    return m_rel;
  endfunction

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vdet = 1'b1; ce = 1'b0; duty3 = 1'b0; ok = 1'b0; grp = '0;
    m_got = '0; m_rel = 1'b0;
    repeat (3) @(negedge clk);
    expect_now("R1 R2 R3 reset state");
    vdet = 1'b0;
    @(negedge clk);
    expect_now("R1 held after detect");

    // quarter duty, ascending, invalid completing frame first
    send_frame(0, 1, "R5 group0 only");
    send_frame(1, 1, "R5 group1");
    send_frame(2, 1, "R5 group2");
    send_frame(3, 0, "R9 invalid frame ignored");
    send_frame(3, 1, "R8 R2 R3 release on final fall");
    send_frame(0, 0, "R10 stays released");
    send_frame(2, 1, "R10 stays released again");

    // detector mid-operation then partial set
    pulse_vdet("R1 async reassert");
    send_frame(0, 1, "R11 marks cleared g0");
    send_frame(1, 1, "R11 marks cleared g1");
    send_frame(2, 1, "R11 partial set holds reset");
    pulse_vdet("R11 second detect");

    // third duty, scrambled with repeats and unused code
    duty3 = 1'b1;
    send_frame(2, 1, "R7 scrambled g2");
    send_frame(2, 1, "R7 repeat g2");
    send_frame(0, 1, "R7 scrambled g0");
    send_frame(3, 1, "R6 unused code ignored");
    send_frame(1, 1, "R6 release third duty");

    pulse_vdet("R1 third duty reassert");
    send_frame(1, 1, "R7 g1 first");
    send_frame(1, 1, "R7 g1 repeat");
    send_frame(0, 1, "R4 g0");
    send_frame(2, 1, "R6 R8 release");

    repeat (3) @(negedge clk);
    -> chk_ev;
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule